// File: doc/BRIEF.md
# Colour Subcarrier Oscillator with Field Reset and Serial Frequency Lock

This block is a numerically controlled oscillator that generates the colour subcarrier phase for a composite video encoder, clocked at twice the pixel rate (27 MHz). Each clock, a phase accumulator adds the active frequency word. A programmable phase offset is added on the way out. The block presents the full phase word and a coarse phase value that indexes a sine/cosine table downstream.

A single control pin serves one of two purposes, chosen by a 2-bit mode input. In field-reset mode, a high-to-low transition on the pin arms a reset. The accumulator then returns to its field-0 value (zero) at the start of the next field, not when the pin falls. In lock mode, the pin carries a serial frame from an external video decoder. The block extracts a new 22-bit frequency from that frame and switches to it at the next line start. This keeps the subcarrier locked to an external source whose line length varies.

Top module: `subcarrier_nco`

## Requirements
- R1: While rst_n is low, the accumulator is zero, so phase_out equals phase_ofs; the reset is asynchronous.
- R2: On every rising clock edge that does not apply a field reset, the accumulator advances by the active frequency. The active frequency is freq_word unless a lock-mode word has been installed (R9).
- R3: phase_out is the accumulator plus phase_ofs, modulo 2^32. phase_q is bits [31:22] of phase_out.
- R4: ctl_mode encodes 0 = pin unused, 1 = field reset, 2 = serial lock, 3 = pin unused. In mode 1, a clock edge that sees ctl_pin low after seeing it high in the previous cycle arms a pending reset.
- R5: A pending reset is applied at the first clock edge with field_start high that comes after the arming edge. That edge loads zero into the accumulator and clears the pending reset, so a later field_start alone does nothing.
- R6: In any mode other than 1, the pending reset is cleared and falling pin edges are ignored. A fall seen before entering mode 1 never resets the phase.
- R7: In mode 2, a low-to-high pin transition while idle starts a frame. The start bit and each of the 67 data bits last 2 clocks, and each bit is sampled on its second clock. Data bits 0..21 form the frequency field, bit 0 arriving first and being the field LSB.
- R8: The 22-bit field is placed in bits [31:10] of the frequency word, and bits [9:0] are zero.
- R9: A received field is committed only after data bit 66 has been sampled. It becomes the active frequency at the next clock edge with line_start high, and the accumulator uses it from the following edge on.
- R10: In mode 2 before any word is installed, and in modes 0, 1 and 3, freq_word is used. Leaving mode 2 discards both the installed word and any committed word that has not yet been applied.
- R11: Pin transitions inside a frame never restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_mode | input | 2 | Control pin function select (R4) |
| ctl_pin | input | 1 | Shared reset / serial lock pin |
| field_start | input | 1 | One-cycle pulse at each field start |
| line_start | input | 1 | One-cycle pulse at each line start |
| freq_word | input | 32 | Programmed frequency increment |
| phase_ofs | input | 32 | Programmed phase offset |
| phase_out | output | 32 | Offset subcarrier phase |
| phase_q | output | 10 | Quantised phase for the sine/cosine table |

## Verification
The assertions assume that ctl_pin, ctl_mode and the two timing pulses are synchronous to clk and change only between edges. They also assume that a serial frame keeps every bit level for exactly two clocks. The stimulus drives all inputs on the falling edge. Frames are produced by a task that holds the start bit and each data bit for two full cycles, and frames are never interleaved with mode changes. The timing pulses are raised for a single cycle, including pulses placed inside a frame and before a frame is committed.

// File: rtl/sc_nco_pkg.sv
package sc_nco_pkg;
   typedef enum logic [1:0] {
      PIN_IDLE  = 2'd0,
      PIN_FRST  = 2'd1,
      PIN_LOCK  = 2'd2,
      PIN_IDLE3 = 2'd3
   } pin_mode_e;
endpackage

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_en,
   input  logic             pin_fall,
   input  logic             field_start,
   input  logic [ACC_W-1:0] freq_i,
   output logic [ACC_W-1:0] acc_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (pend_q && field_start) acc_o <= '0;
         else                       acc_o <= acc_o + freq_i;

         if (!arm_en)                    pend_q <= 1'b0;
         else if (pin_fall)              pend_q <= 1'b1;
         else if (field_start && pend_q) pend_q <= 1'b0;
      end
   end

   assert_field_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && field_start) |=> (acc_o == '0));
   assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_en && pin_fall) |=> pend_q);
   assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_en |=> !pend_q);
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_q && field_start) |=> (acc_o == $past(acc_o) + $past(freq_i)));
endmodule

// File: rtl/sc_lock_rx.sv
module sc_lock_rx #(
   parameter int ACC_W    = 32,
   parameter int FIELD_W  = 22,
   parameter int RTC_LEN  = 67,
   parameter int BIT_CLKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pin,
   input  logic             pin_rise,
   input  logic             line_start,
   output logic [ACC_W-1:0] freq_o,
   output logic             have_o
);
   localparam int PH_W   = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
   localparam int SLOT_W = $clog2(RTC_LEN + 1);
   localparam logic [PH_W-1:0]   PH_LAST = PH_W'(BIT_CLKS - 1);
   localparam logic [PH_W-1:0]   PH_MID  = PH_W'(BIT_CLKS / 2);
   localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(RTC_LEN);

   logic                busy_q;
   logic [PH_W-1:0]     ph_q;
   logic [SLOT_W-1:0]   slot_q;
   logic [FIELD_W-1:0]  fld_q, stg_q, rf_q;
   logic                stg_vld_q;
   logic                sample, commit;
   logic [FIELD_W-1:0]  hit;

   assign sample = busy_q && (ph_q == PH_MID) && (slot_q != '0);
   assign commit = en && sample && (slot_q == SLOT_END);

   for (genvar i = 0; i < FIELD_W; i++) begin : g_hit
      assign hit[i] = en && sample && (slot_q == SLOT_W'(i + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         ph_q      <= '0;
         slot_q    <= '0;
         fld_q     <= '0;
         stg_q     <= '0;
         stg_vld_q <= 1'b0;
         rf_q      <= '0;
         have_o    <= 1'b0;
      end else begin
         fld_q <= (fld_q & ~hit) | (hit & {FIELD_W{pin}});
         if (!en) begin
            busy_q    <= 1'b0;
            stg_vld_q <= 1'b0;
            have_o    <= 1'b0;
         end else begin
            if (busy_q) begin
               if (ph_q == PH_LAST) begin
                  ph_q   <= '0;
                  slot_q <= slot_q + 1'b1;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
               if (commit) busy_q <= 1'b0;
            end else if (pin_rise) begin
               busy_q <= 1'b1;
               ph_q   <= PH_W'(1);
               slot_q <= '0;
            end

            if (line_start && stg_vld_q) begin
               rf_q   <= stg_q;
               have_o <= 1'b1;
            end

            if (commit) begin
               stg_q     <= fld_q;
               stg_vld_q <= 1'b1;
            end else if (line_start && stg_vld_q) begin
               stg_vld_q <= 1'b0;
            end
         end
      end
   end

   if (ACC_W > FIELD_W) begin : g_left
      assign freq_o = {rf_q, {(ACC_W - FIELD_W){1'b0}}};
   end else begin : g_full
      assign freq_o = rf_q;
   end

   assert_frame_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (slot_q <= SLOT_END));
   assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!have_o && !stg_vld_q));
   assert_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && line_start && stg_vld_q && !commit) |=> (!stg_vld_q && have_o));
   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy_q && !commit) |=> (slot_q >= $past(slot_q)));
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco #(
   parameter int ACC_W    = 32,
   parameter int FIELD_W  = 22,
   parameter int RTC_LEN  = 67,
   parameter int BIT_CLKS = 2,
   parameter int Q_W      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ctl_mode,
   input  logic             ctl_pin,
   input  logic             field_start,
   input  logic             line_start,
   input  logic [ACC_W-1:0] freq_word,
   input  logic [ACC_W-1:0] phase_ofs,
   output logic [ACC_W-1:0] phase_out,
   output logic [Q_W-1:0]   phase_q
);
   import sc_nco_pkg::*;

   if (FIELD_W > ACC_W) begin : g_chk_field
      $error("FIELD_W must not exceed ACC_W");
   end
   if (Q_W > ACC_W || Q_W < 1) begin : g_chk_q
      $error("Q_W must lie in 1..ACC_W");
   end
   if (RTC_LEN <= FIELD_W) begin : g_chk_len
      $error("RTC_LEN must exceed FIELD_W");
   end
   if (BIT_CLKS < 2) begin : g_chk_bit
      $error("BIT_CLKS must be at least 2");
   end

   pin_mode_e        mode;
   logic             pin_d;
   logic             pin_rise, pin_fall;
   logic [ACC_W-1:0] rx_freq, act_freq, acc;
   logic             rx_have;

   assign mode = pin_mode_e'(ctl_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= 1'b0;
      else        pin_d <= ctl_pin;
   end

   assign pin_rise = ~pin_d & ctl_pin;
   assign pin_fall = pin_d & ~ctl_pin;

   sc_lock_rx #(
      .ACC_W(ACC_W), .FIELD_W(FIELD_W), .RTC_LEN(RTC_LEN), .BIT_CLKS(BIT_CLKS)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .en(mode == PIN_LOCK), .pin(ctl_pin),
      .pin_rise(pin_rise), .line_start(line_start),
      .freq_o(rx_freq), .have_o(rx_have)
   );

   assign act_freq = (mode == PIN_LOCK && rx_have) ? rx_freq : freq_word;

   sc_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .arm_en(mode == PIN_FRST), .pin_fall(pin_fall),
      .field_start(field_start), .freq_i(act_freq), .acc_o(acc)
   );

   assign phase_out = acc + phase_ofs;
   assign phase_q   = phase_out[ACC_W-1 -: Q_W];

   assert_reg_freq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != PIN_LOCK) |-> (act_freq == freq_word));
   assert_reset_hold_R1: assert property (@(posedge clk)
      !rst_n |-> (phase_out == phase_ofs));
endmodule

// File: tb/sim_subcarrier_nco.sv
`timescale 1ns/1ps
module sim_subcarrier_nco;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ctl_mode = 2'd0;
   logic        ctl_pin = 1'b0;
   logic        field_start = 1'b0;
   logic        line_start = 1'b0;
   logic [31:0] freq_word = 32'd0;
   logic [31:0] phase_ofs = 32'h1234_5678;
   logic [31:0] phase_out;
   logic [9:0]  phase_q;

   int n_run = 0;
   int n_fail = 0;
   string cur_tag = "R1";

   always #4 clk = ~clk;

   subcarrier_nco u0 (
      .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .ctl_pin(ctl_pin),
      .field_start(field_start), .line_start(line_start),
      .freq_word(freq_word), .phase_ofs(phase_ofs),
      .phase_out(phase_out), .phase_q(phase_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [31:0] m_acc, m_rf;
   bit [21:0] m_fld, m_stg;
   bit m_pend, m_prev, m_busy, m_svld, m_have;
   int m_cyc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_rf = 0; m_fld = 0; m_stg = 0;
         m_pend = 0; m_prev = 0; m_busy = 0; m_svld = 0; m_have = 0; m_cyc = 0;
      end else begin
         bit [31:0] fa, n_acc;
         bit rise, fall, n_pend, commit, apply;
         fa = (ctl_mode == 2'd2 && m_have) ? m_rf : freq_word;
         rise = !m_prev && ctl_pin;
         fall = m_prev && !ctl_pin;
         n_acc = (m_pend && field_start) ? 32'd0 : m_acc + fa;
         if (ctl_mode != 2'd1) n_pend = 0;
         else if (fall) n_pend = 1;
         else if (field_start && m_pend) n_pend = 0;
         else n_pend = m_pend;
         if (ctl_mode != 2'd2) begin
            m_busy = 0; m_svld = 0; m_have = 0;
         end else begin
            commit = 0;
            apply = line_start && m_svld;
            if (m_busy) begin
               m_cyc++;
               if (m_cyc >= 3 && (m_cyc % 2) == 1) begin
                  int k;
                  k = (m_cyc - 3) / 2;
                  if (k < 22) m_fld[k] = ctl_pin;
                  if (k == 66) begin m_busy = 0; commit = 1; end
               end
            end else if (rise) begin
               m_busy = 1; m_cyc = 0;
            end
            if (apply) begin m_rf = {m_stg, 10'b0}; m_have = 1; m_svld = 0; end
            if (commit) begin m_stg = m_fld; m_svld = 1; end
         end
         m_acc = n_acc; m_pend = n_pend; m_prev = ctl_pin;
      end
      #2;
      if (rst_n) begin
         chk({cur_tag, " R3 phase"}, phase_out, m_acc + phase_ofs);
         chk("R3 quant", {22'd0, phase_q}, {22'd0, phase_out[31:22]});
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_fs;
      @(negedge clk) field_start = 1'b1;
      @(negedge clk) field_start = 1'b0;
   endtask

   task automatic pulse_ls;
      @(negedge clk) line_start = 1'b1;
      @(negedge clk) line_start = 1'b0;
   endtask

   task automatic send_frame(input logic [66:0] b);
      @(negedge clk) ctl_pin = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 67; k++) begin
         @(negedge clk) ctl_pin = b[k];
         @(negedge clk);
      end
      @(negedge clk) ctl_pin = 1'b0;
   endtask

   task automatic chk_step(input string tag, input logic [31:0] step);
      logic [31:0] p0;
      @(posedge clk); #3;
      p0 = phase_out;
      repeat (8) @(posedge clk);
      #3;
      chk(tag, phase_out - p0, step * 32'd8);
   endtask

   bit done = 0;
   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [66:0] fr;
      #1;
      chk("R1 reset phase", phase_out, 32'h1234_5678);
      freq_word = 32'h0100_0000;
      cyc(2);
      chk("R1 reset held", phase_out, 32'h1234_5678);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #3;
      chk("R1 first step", phase_out, 32'h1334_5678);

      cur_tag = "R2";
      @(negedge clk) freq_word = 32'h0123_4567; phase_ofs = 32'hF000_0001;
      chk_step("R2 step", 32'h0123_4567);
      @(negedge clk) freq_word = 32'hFFFF_FFF0;
      chk_step("R2 wrap step", 32'hFFFF_FFF0);

      cur_tag = "R4";
      @(negedge clk) ctl_mode = 2'd1; freq_word = 32'h0765_4321;
      @(negedge clk) ctl_pin = 1'b1;
      @(negedge clk) ctl_pin = 1'b0;
      cyc(4);
      @(posedge clk); #3;
      chk("R4 no immediate reset", {31'd0, phase_out == phase_ofs}, 32'd0);
      cur_tag = "R5";
      @(negedge clk) field_start = 1'b1;
      @(posedge clk); #3;
      chk("R5 field zero", phase_out, phase_ofs);
      @(negedge clk) field_start = 1'b0;
      cyc(3);
      @(negedge clk) field_start = 1'b1;
      @(posedge clk); #3;
      chk("R5 single shot", {31'd0, phase_out == phase_ofs}, 32'd0);
      @(negedge clk) field_start = 1'b0;

      cur_tag = "R6";
      @(negedge clk) ctl_mode = 2'd0; ctl_pin = 1'b1;
      @(negedge clk) ctl_pin = 1'b0;
      @(negedge clk) ctl_mode = 2'd1;
      cyc(2);
      @(negedge clk) field_start = 1'b1;
      @(posedge clk); #3;
      chk("R6 fall outside mode ignored", {31'd0, phase_out == phase_ofs}, 32'd0);
      @(negedge clk) field_start = 1'b0;
      @(negedge clk) ctl_pin = 1'b1;
      @(negedge clk) ctl_pin = 1'b0; ctl_mode = 2'd3;
      @(negedge clk) ctl_mode = 2'd1;
      pulse_fs();
      @(posedge clk); #3;
      chk("R6 disarm on leave", {31'd0, phase_out == phase_ofs}, 32'd0);

      cur_tag = "R10";
      @(negedge clk) ctl_mode = 2'd2; freq_word = 32'h0011_2233;
      pulse_ls();
      chk_step("R10 lock mode before word", 32'h0011_2233);

      cur_tag = "R9";
      fr = {45'h0A5A_5A5A_5A5A, 22'h2A5C3};
      fork
         send_frame(fr);
         begin cyc(60); pulse_ls(); end
      join
      chk_step("R9 not applied before line", 32'h0011_2233);
      cur_tag = "R8";
      pulse_ls();
      chk_step("R8 field left aligned", {22'h2A5C3, 10'd0});

      cur_tag = "R7";
      fr = {45'h1555_5555_5555, 22'h00001};
      send_frame(fr);
      pulse_ls();
      chk_step("R7 bit0 is lsb", 32'h0000_0400);
      fr = {45'h0, 22'h3F0F0};
      cur_tag = "R11";
      send_frame(fr);
      pulse_ls();
      chk_step("R11 frame with edges", {22'h3F0F0, 10'd0});

      cur_tag = "R10";
      @(negedge clk) ctl_mode = 2'd0;
      chk_step("R10 leave lock", 32'h0011_2233);
      @(negedge clk) ctl_mode = 2'd2;
      pulse_ls();
      chk_step("R10 word discarded", 32'h0011_2233);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule